// File: doc/BRIEF.md
# Single-Channel Peripheral-to-Memory Byte Mover

This block moves a block of bytes from a peripheral into memory without the CPU touching each byte. Software loads a start address and a byte count, then starts the channel. For every byte the peripheral supplies, the engine holds that byte in an internal register. It then asks for the shared memory bus, writes the byte once the bus is granted, and steps its address up and its count down. When the count runs out, it raises one interrupt for the whole block.

A small arbiter model is included with the engine. It shares the bus between the CPU and the engine, and the CPU always has priority. The engine gives up the bus after every byte, so the CPU is never locked out for more than one write cycle.

Top module: `dma_byte_engine`

## Requirements
- R1: After reset, irq_o, bus_req_o, bus_gnt_o, mem_we_o and periph_take_o are all low.
- R2: Configuration writes use cfg_sel_i: 0 loads the address, 1 loads the length, and 2 is control (bit 0 starts the channel, bit 1 clears the interrupt). A start with a non-zero length raises periph_take_o in the next cycle. A periph_valid_i pulse while periph_take_o is high captures periph_data_i and drops periph_take_o.
- R3: From the cycle after a byte is captured, bus_req_o stays high until that byte has been written.
- R4: mem_we_o is high only in a cycle where bus_gnt_o is high and cpu_gnt_o is low. The write carries the captured byte, even if periph_data_i has changed since the capture.
- R5: Each write goes to the current address. The address then rises by one, wrapping at its width, and the length falls by one. Exactly as many writes occur as the programmed length.
- R6: bus_gnt_o is never high in the cycle after a cycle in which cpu_req_i was high, and it is never high together with cpu_gnt_o.
- R7: bus_req_o is low in the cycle after each memory write.
- R8: irq_o goes high in the cycle after the final write and stays high until a control write with bit 1 set.
- R9: A start with a length of zero raises irq_o in the next cycle and causes no bus request or write.
- R10: While the channel is active, writes to the address register, the length register and the start bit are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Register select: 0 address, 1 length, 2 control |
| cfg_wdata_i | input | CW | Configuration write data |
| periph_valid_i | input | 1 | Peripheral byte-ready strobe |
| periph_data_i | input | DW | Peripheral byte |
| periph_take_o | output | 1 | Engine is waiting for the next byte |
| cpu_req_i | input | 1 | CPU wants the memory bus |
| cpu_gnt_o | output | 1 | CPU owns the bus this cycle |
| bus_req_o | output | 1 | Engine bus request |
| bus_gnt_o | output | 1 | Engine bus grant |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | AW | Memory write address |
| mem_wdata_o | output | DW | Memory write data |
| irq_o | output | 1 | Block-complete interrupt |

## Verification
A wrong address or a wrong byte shows up on mem_addr_o or mem_wdata_o in the very write cycle it affects. A miscounted length only shows at the end of the block: either an extra write appears, or irq_o rises early, late or not at all. An arbiter fault shows within one cycle, as a write that overlaps a CPU grant or that follows a CPU request. Configuration writes made during a transfer would bend the address sequence or the write count of that same block, so they are caught before irq_o rises.

// File: rtl/dma_eng_pkg.sv
package dma_eng_pkg;
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_WAIT = 2'd1,
    XS_REQ  = 2'd2
  } xfer_st_e;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_LEN  = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;
  localparam int CTRL_START = 0;
  localparam int CTRL_CLEAR = 1;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_eng_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          active_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          start_o,
  output logic          irq_o
);
  localparam logic [AW-1:0] ADDR_ONE = AW'(1);
  localparam logic [LW-1:0] LEN_ONE  = LW'(1);

  logic [AW-1:0] addr_q;
  logic [LW-1:0] len_q;
  logic          irq_q;
  logic          ctrl_wr, start_acc, zero_start, clr_req, done_evt;

  assign ctrl_wr    = cfg_we_i && (cfg_sel_i == SEL_CTRL);
  assign start_acc  = ctrl_wr && cfg_wdata_i[CTRL_START] && !active_i;
  assign zero_start = start_acc && (len_q == '0);
  assign clr_req    = ctrl_wr && cfg_wdata_i[CTRL_CLEAR];
  assign last_o     = (len_q == LEN_ONE);
  assign done_evt   = step_i && last_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      len_q  <= '0;
    end else if (step_i) begin
      addr_q <= addr_q + ADDR_ONE;
      len_q  <= len_q - LEN_ONE;
    end else if (cfg_we_i && !active_i) begin
      if (cfg_sel_i == SEL_ADDR) addr_q <= cfg_wdata_i[AW-1:0];
      if (cfg_sel_i == SEL_LEN)  len_q  <= cfg_wdata_i[LW-1:0];
    end
  end

  // completion wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     irq_q <= 1'b0;
    else if (done_evt || zero_start) irq_q <= 1'b1;
    else if (clr_req)                irq_q <= 1'b0;
  end

  assign addr_o  = addr_q;
  assign start_o = start_acc && (len_q != '0);
  assign irq_o   = irq_q;

  a_r5_len_steps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> len_q == $past(len_q) - LEN_ONE);
  a_r10_addr_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !step_i) |=> $stable(addr_q));
  a_r10_len_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !step_i) |=> $stable(len_q));
  a_r8_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !clr_req) |=> irq_q);
  a_r9_zero_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_start |=> irq_q);
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm
  import dma_eng_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          last_i,
  input  logic          pvalid_i,
  input  logic [DW-1:0] pdata_i,
  input  logic          gnt_i,
  output logic          take_o,
  output logic          req_o,
  output logic          we_o,
  output logic [DW-1:0] data_o,
  output logic          active_o
);
  xfer_st_e      st_q, st_d;
  logic [DW-1:0] data_q;

  assign take_o   = (st_q == XS_WAIT);
  assign req_o    = (st_q == XS_REQ);
  assign we_o     = req_o && gnt_i;
  assign active_o = (st_q != XS_IDLE);
  assign data_o   = data_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      XS_IDLE: if (start_i) st_d = XS_WAIT;
      XS_WAIT: if (pvalid_i) st_d = XS_REQ;
      XS_REQ:  if (gnt_i) st_d = last_i ? XS_IDLE : XS_WAIT;
      default: st_d = XS_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= XS_IDLE;
    else         st_q <= st_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                pdata_hold_reset: data_q <= '0;
    else if (take_o && pvalid_i) data_q <= pdata_i;
  end

  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !we_o) |=> req_o);
  a_r7_req_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |=> !req_o);
  a_r2_capture_to_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_o && pvalid_i) |=> (req_o && !take_o));
endmodule

// File: rtl/dma_bus_arb.sv
module dma_bus_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cpu_req_i,
  input  logic dma_req_i,
  input  logic dma_done_i,
  output logic dma_gnt_o,
  output logic cpu_gnt_o
);
  logic dma_gnt_q;

  // CPU request blocks the next engine grant; grant ends with the write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dma_gnt_q <= 1'b0;
    else         dma_gnt_q <= dma_req_i && !cpu_req_i && !dma_done_i;
  end

  assign dma_gnt_o = dma_gnt_q;
  assign cpu_gnt_o = cpu_req_i && !dma_gnt_q;

  a_r6_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_gnt_o && dma_gnt_o));
  a_r6_cpu_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_req_i |=> !dma_gnt_o);
  a_r4_gnt_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_gnt_o |-> $past(dma_req_i));
endmodule

// File: rtl/dma_byte_engine.sv
module dma_byte_engine #(
  parameter int AW = 16,
  parameter int LW = 16,
  parameter int DW = 8,
  localparam int CW = (AW > LW) ? AW : LW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [CW-1:0] cfg_wdata_i,
  input  logic          periph_valid_i,
  input  logic [DW-1:0] periph_data_i,
  output logic          periph_take_o,
  input  logic          cpu_req_i,
  output logic          cpu_gnt_o,
  output logic          bus_req_o,
  output logic          bus_gnt_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          irq_o
);
  logic active, step, last, start;

  dma_cfg_regs #(.AW(AW), .LW(LW), .CW(CW)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_we_i    (cfg_we_i),
    .cfg_sel_i   (cfg_sel_i),
    .cfg_wdata_i (cfg_wdata_i),
    .active_i    (active),
    .step_i      (step),
    .addr_o      (mem_addr_o),
    .last_o      (last),
    .start_o     (start),
    .irq_o       (irq_o)
  );

  dma_xfer_fsm #(.DW(DW)) u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .last_i   (last),
    .pvalid_i (periph_valid_i),
    .pdata_i  (periph_data_i),
    .gnt_i    (bus_gnt_o),
    .take_o   (periph_take_o),
    .req_o    (bus_req_o),
    .we_o     (step),
    .data_o   (mem_wdata_o),
    .active_o (active)
  );

  dma_bus_arb u_arb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpu_req_i  (cpu_req_i),
    .dma_req_i  (bus_req_o),
    .dma_done_i (step),
    .dma_gnt_o  (bus_gnt_o),
    .cpu_gnt_o  (cpu_gnt_o)
  );

  assign mem_we_o = step;

  a_r4_write_in_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (bus_gnt_o && !cpu_gnt_o && bus_req_o));
  a_r9_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !bus_req_o);
endmodule

// File: tb/dma_byte_engine_tb_top.sv
`timescale 1ns/1ps
module dma_byte_engine_tb_top;
  localparam int AW = 16;
  localparam int LW = 16;
  localparam int DW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_we = 1'b0;
  logic [1:0]    cfg_sel = '0;
  logic [CW-1:0] cfg_wdata = '0;
  logic          pvalid = 1'b0;
  logic [DW-1:0] pdata = '0;
  logic          ptake, cpu_req, cpu_gnt, bus_req, bus_gnt, mem_we, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  always #4 clk = ~clk;

  dma_byte_engine #(.AW(AW), .LW(LW), .DW(DW)) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .cfg_we_i (cfg_we), .cfg_sel_i (cfg_sel),
    .cfg_wdata_i (cfg_wdata), .periph_valid_i (pvalid), .periph_data_i (pdata),
    .periph_take_o (ptake), .cpu_req_i (cpu_req), .cpu_gnt_o (cpu_gnt),
    .bus_req_o (bus_req), .bus_gnt_o (bus_gnt), .mem_we_o (mem_we),
    .mem_addr_o (mem_addr), .mem_wdata_o (mem_wdata), .irq_o (irq)
  );

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  // monitor and CPU request driver
  bit            cpu_force = 1'b0;
  bit            cpu_rand  = 1'b0;
  logic          prev_cpu_req = 1'b0;
  logic          prev_we = 1'b0;
  int            wr_cnt = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [DW-1:0] exp_byte = '0;
  initial cpu_req = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_we) chk(bus_req == 1'b0, "R7", "bus_req after write", bus_req, 0);
      if (mem_we) begin
        chk(mem_addr == exp_addr, "R5", "write address", mem_addr, exp_addr);
        chk(mem_wdata == exp_byte, "R4", "write data", mem_wdata, exp_byte);
        chk(!prev_cpu_req && !cpu_gnt, "R6", "grant vs cpu", {prev_cpu_req, cpu_gnt}, 0);
        exp_addr = next_addr(exp_addr);
        wr_cnt++;
      end
      prev_we = mem_we;
    end
    if (cpu_force)     cpu_req = 1'b1;
    else if (cpu_rand) cpu_req = (($urandom % 4) == 0);
    else               cpu_req = 1'b0;
    prev_cpu_req = cpu_req;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cfg_write(input logic [1:0] sel, input logic [CW-1:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_block(input logic [AW-1:0] a, input int len,
                           input bit tamper, input bit stall);
    cfg_write(2'd0, a);
    cfg_write(2'd1, CW'(len));
    exp_addr = a;
    wr_cnt = 0;
    cfg_write(2'd2, 16'h0001);
    chk(ptake == 1'b1, "R2", "take after start", ptake, 1);
    for (int i = 0; i < len; i++) begin
      logic [DW-1:0] b;
      int t;
      while (!ptake) @(negedge clk);
      if (tamper && i == 0) begin
        cfg_write(2'd0, ~a);
        cfg_write(2'd1, 16'd2);
        cfg_write(2'd2, 16'h0001);
        chk(ptake == 1'b1, "R10", "state after ignored writes", ptake, 1);
      end
      if (stall && i == 0) begin
        cpu_force = 1'b1;
        @(negedge clk);
        @(negedge clk);
      end
      b = DW'($urandom);
      pvalid = 1'b1; pdata = b; exp_byte = b;
      chk(irq == 1'b0, "R8", "irq before end", irq, 0);
      @(negedge clk);
      pvalid = 1'b0; pdata = ~b;
      chk(ptake == 1'b0, "R2", "take drops on capture", ptake, 0);
      chk(bus_req == 1'b1, "R3", "request after capture", bus_req, 1);
      if (stall && i == 0) begin
        for (int k = 0; k < 6; k++) begin
          @(negedge clk);
          chk(mem_we == 1'b0 && bus_req == 1'b1, "R6", "write held off by cpu",
              {mem_we, bus_req}, 2'b01);
        end
        cpu_force = 1'b0;
      end
      t = 0;
      while (!mem_we && t < 60) begin
        @(negedge clk);
        t++;
      end
      chk(mem_we == 1'b1, "R3", "write reached", mem_we, 1);
      if (i == len - 1) begin
        chk(irq == 1'b0, "R8", "irq during last write", irq, 0);
        @(negedge clk);
        chk(irq == 1'b1, "R8", "irq after last write", irq, 1);
      end else begin
        @(negedge clk);
      end
    end
    repeat (3) @(negedge clk);
    chk(irq == 1'b1, "R8", "irq held", irq, 1);
    chk(wr_cnt == len, "R5", "write count", wr_cnt, len);
    chk(exp_addr == a + AW'(len), "R5", "final address", exp_addr, a + AW'(len));
    cfg_write(2'd2, 16'h0002);
    chk(irq == 1'b0, "R8", "irq cleared", irq, 0);
  endtask

  initial begin
    void'($urandom(32'h5eed_0011));
    repeat (3) @(negedge clk);
    chk({irq, bus_req, bus_gnt, mem_we, ptake} == 5'b0, "R1", "reset outputs",
        {irq, bus_req, bus_gnt, mem_we, ptake}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({irq, bus_req, bus_gnt, mem_we, ptake} == 5'b0, "R1", "idle after reset",
        {irq, bus_req, bus_gnt, mem_we, ptake}, 0);

    run_block(16'hFFFE, 4, 1'b0, 1'b0);   // R5 address wrap
    run_block(16'h0100, 3, 1'b1, 1'b0);   // R10 writes while active
    run_block(16'h2000, 2, 1'b0, 1'b1);   // R6 cpu holds the bus

    // R9 zero length
    cfg_write(2'd1, 16'd0);
    wr_cnt = 0;
    cfg_write(2'd2, 16'h0001);
    chk(irq == 1'b1, "R9", "zero length irq", irq, 1);
    chk(ptake == 1'b0, "R9", "zero length take", ptake, 0);
    repeat (4) begin
      @(negedge clk);
      chk(bus_req == 1'b0 && wr_cnt == 0, "R9", "zero length no bus",
          {bus_req, wr_cnt[3:0]}, 0);
    end
    cfg_write(2'd2, 16'h0002);
    chk(irq == 1'b0, "R8", "irq cleared after zero length", irq, 0);

    cpu_rand = 1'b1;
    for (int n = 0; n < 8; n++)
      run_block(AW'($urandom), 1 + int'($urandom % 8), 1'b0, 1'b0);
    cpu_rand = 1'b0;

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule